// File: doc/BRIEF.md
# Toeplitz Hash Privacy Amplifier

This block shortens a reconciled key into a final secret key. It applies a binary Toeplitz hash over GF(2). The key (N bits) and the matrix seed (up to 2N-1 bits) are loaded into two local register stores through narrow write ports, B bits per write. A start command carries a security factor. The block turns that factor into an output length m, multiplies the m-by-N Toeplitz matrix by the key column, and streams the m result bits out in B-bit beats.

The matrix is never expanded. Each B-by-B tile of the matrix is cut straight out of the seed store as a window of 2B-1 consecutive seed bits. One tile product is formed and folded into the row accumulator every clock. A full output beat is therefore ready after N/B clocks, and the whole hash takes (m/B)*(N/B) clocks. While a hash is running, the block refuses new data and new start commands.

Top module: `toeplitz_pa`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `busy`, `out_valid`, `done` and `start_err` are 0. A reset applied during a run abandons that run.
- R2: A start accepted with factor `sfactor` (an unsigned fraction with SF_W fractional bits) sets m = floor(N*sfactor / 2^SF_W), rounded down to a multiple of B. The run then produces exactly m/B `out_valid` beats.
- R3: Result row i (0 <= i < m) is the XOR over all j in 0..N-1 of seed[i-j+N-1] AND key[j]. Beat r carries rows r*B..r*B+B-1, with row r*B+k on `out_data` bit k. Beats come out in increasing r.
- R4: A write to the key store at word address a with data d sets key bit a*B+t to d[t]. A write to the seed store at address a sets seed bit a*B+t to d[t]. Both writes apply only when the block is idle.
- R5: If a start is sampled at clock edge E, beat r appears on the output (r+1)*(N/B) clock edges after E. `done` is a one-cycle pulse that comes with the last beat. If m = 0, `done` pulses right after E and no beat is produced.
- R6: A start sampled while `busy` is 1 is ignored. It raises `start_err` for exactly the next cycle and leaves the running hash unchanged.
- R7: Writes to either store while `busy` is 1 are dropped. Both the current result and later results use the earlier contents.
- R8: `busy` rises on the edge that accepts a start with m > 0. It stays high until the edge that raises `done`, and it is 0 while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_we | input | 1 | Key store write enable |
| key_waddr | input | $clog2(N/B) | Key word address |
| key_wdata | input | B | Key word data |
| seed_we | input | 1 | Seed store write enable |
| seed_waddr | input | $clog2(2N/B) | Seed word address |
| seed_wdata | input | B | Seed word data |
| start | input | 1 | Start a hash |
| sfactor | input | SF_W | Security factor, unsigned fraction |
| busy | output | 1 | Hash in progress |
| out_valid | output | 1 | `out_data` holds a result beat |
| out_data | output | B | B result bits, lowest row in bit 0 |
| done | output | 1 | Last beat / completion pulse |
| start_err | output | 1 | Start refused because busy |

## Verification
The bench targets several corner cases, each tied to a likely defect:
- Factors whose raw length is not a multiple of B (7 becomes 4), plus the largest factor. A sizer that rounds up or truncates wrongly gives the wrong beat count.
- A factor so small that m = 0. A design that enters its run loop anyway emits stray beats or never signals completion.
- A single key bit paired with a single seed bit. This exposes any swapped or offset diagonal index: the lone 1 lands in the wrong row.
- A start and store writes injected mid-run, followed by a rerun without reloading. A design that restarts, or that lets the writes through, shows a wrong latency, a wrong result or corrupted stored data.

// File: rtl/pa_pkg.sv
package pa_pkg;

   typedef enum logic {
      PA_IDLE = 1'b0,
      PA_RUN  = 1'b1
   } pa_state_e;

   function automatic bit pa_is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/pa_bit_store.sv
module pa_bit_store #(
   parameter int WORDS = 16,
   parameter int B     = 4,
   localparam int AW   = $clog2(WORDS),
   localparam int W    = WORDS * B
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lock,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [B-1:0]  wdata,
   output logic [W-1:0]  q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (we && !lock) begin
         q[32'(waddr) * B +: B] <= wdata;
      end
   end

endmodule

// File: rtl/pa_len_calc.sv
module pa_len_calc #(
   parameter int N     = 64,
   parameter int B     = 4,
   parameter int SF_W  = 16,
   localparam int LOGB = $clog2(B),
   localparam int RBW  = $clog2(N / B),
   localparam int PW   = SF_W + $clog2(N + 1)
) (
   input  logic [SF_W-1:0] sf,
   output logic [RBW-1:0]  nblk
);

   logic [PW-1:0] prod;
   logic [PW-1:0] m_raw;

   assign prod  = PW'(N) * PW'(sf);
   assign m_raw = prod >> SF_W;
   // floor to a whole number of B-row tiles
   assign nblk  = RBW'(m_raw >> LOGB);

endmodule

// File: rtl/pa_tile_mul.sv
module pa_tile_mul #(
   parameter int B    = 4,
   localparam int WW  = 2 * B - 1
) (
   input  logic [WW-1:0] win,
   input  logic [B-1:0]  kb,
   output logic [B-1:0]  prod
);

   // tile element (r, c) sits on window diagonal r - c + B - 1
   for (genvar r = 0; r < B; r++) begin : g_row
      logic [B-1:0] terms;
      for (genvar c = 0; c < B; c++) begin : g_col
         assign terms[c] = win[r - c + B - 1] & kb[c];
      end
      assign prod[r] = ^terms;
   end

endmodule

// File: rtl/toeplitz_pa.sv
module toeplitz_pa #(
   parameter int N     = 64,
   parameter int B     = 4,
   parameter int SF_W  = 16,
   localparam int NCB  = N / B,
   localparam int CBW  = $clog2(NCB),
   localparam int RBW  = $clog2(NCB),
   localparam int KAW  = $clog2(NCB),
   localparam int SAW  = $clog2(2 * NCB),
   localparam int SW   = $clog2(2 * N),
   localparam int WW   = 2 * B - 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            key_we,
   input  logic [KAW-1:0]  key_waddr,
   input  logic [B-1:0]    key_wdata,
   input  logic            seed_we,
   input  logic [SAW-1:0]  seed_waddr,
   input  logic [B-1:0]    seed_wdata,
   input  logic            start,
   input  logic [SF_W-1:0] sfactor,
   output logic            busy,
   output logic            out_valid,
   output logic [B-1:0]    out_data,
   output logic            done,
   output logic            start_err
);
   import pa_pkg::*;

   if (!pa_is_pow2(B) || B < 2) begin : g_bad_tile
      $error("tile size B must be a power of two of at least 2");
   end
   if ((N % B) != 0 || NCB < 2 || !pa_is_pow2(NCB)) begin : g_bad_len
      $error("N must be a power-of-two multiple of B holding at least two tiles");
   end
   if (SF_W < 1 || SF_W > 24) begin : g_bad_sf
      $error("SF_W out of supported range");
   end

   pa_state_e         state;
   logic [RBW-1:0]    rb;
   logic [CBW-1:0]    cb;
   logic [RBW-1:0]    nrb_q;
   logic [RBW-1:0]    nrb_calc;
   logic [B-1:0]      acc;
   logic [B-1:0]      tile_prod;
   logic [B-1:0]      acc_next;
   logic [N-1:0]      key_q;
   logic [2*N-1:0]    seed_q;
   logic [SW-1:0]     win_lo;
   logic [WW-1:0]     win;
   logic [B-1:0]      kb;

   assign busy = (state == PA_RUN);

   pa_bit_store #(.WORDS(NCB), .B(B)) u_key (
      .clk   (clk),
      .rst_n (rst_n),
      .lock  (busy),
      .we    (key_we),
      .waddr (key_waddr),
      .wdata (key_wdata),
      .q     (key_q)
   );

   pa_bit_store #(.WORDS(2 * NCB), .B(B)) u_seed (
      .clk   (clk),
      .rst_n (rst_n),
      .lock  (busy),
      .we    (seed_we),
      .waddr (seed_waddr),
      .wdata (seed_wdata),
      .q     (seed_q)
   );

   pa_len_calc #(.N(N), .B(B), .SF_W(SF_W)) u_len (
      .sf   (sfactor),
      .nblk (nrb_calc)
   );

   // lowest seed index touched by tile (rb, cb): rb*B - cb*B + N - B
   assign win_lo = SW'(32'(rb) * B + (N - B) - 32'(cb) * B);
   assign win    = seed_q[32'(win_lo) +: WW];
   assign kb     = key_q[32'(cb) * B +: B];

   pa_tile_mul #(.B(B)) u_mul (
      .win  (win),
      .kb   (kb),
      .prod (tile_prod)
   );

   assign acc_next = acc ^ tile_prod;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= PA_IDLE;
         rb        <= '0;
         cb        <= '0;
         nrb_q     <= '0;
         acc       <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
         done      <= 1'b0;
         start_err <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         done      <= 1'b0;
         start_err <= start && (state == PA_RUN);
         case (state)
            PA_IDLE: begin
               if (start) begin
                  if (nrb_calc == '0) begin
                     done <= 1'b1;
                  end else begin
                     nrb_q <= nrb_calc;
                     rb    <= '0;
                     cb    <= '0;
                     acc   <= '0;
                     state <= PA_RUN;
                  end
               end
            end
            PA_RUN: begin
               if (cb == CBW'(NCB - 1)) begin
                  out_valid <= 1'b1;
                  out_data  <= acc_next;
                  acc       <= '0;
                  cb        <= '0;
                  if (rb == RBW'(nrb_q - 1'b1)) begin
                     state <= PA_IDLE;
                     done  <= 1'b1;
                  end else begin
                     rb <= rb + 1'b1;
                  end
               end else begin
                  acc <= acc_next;
                  cb  <= cb + 1'b1;
               end
            end
            default: state <= PA_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pa_checker.sv
module pa_checker #(
   parameter int N    = 64,
   parameter int B    = 4,
   parameter int SF_W = 16,
   localparam int NCB = N / B
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic [SF_W-1:0] sfactor,
   input logic            busy,
   input logic            out_valid,
   input logic [B-1:0]    out_data,
   input logic            done,
   input logic            start_err
);

   logic [31:0] lat_cnt;
   logic [31:0] lat_exp;
   logic [31:0] beat_cnt;
   logic [31:0] beat_exp;
   logic [63:0] blk_calc;

   assign blk_calc = ((64'(N) * 64'(sfactor)) >> SF_W) / 64'(B);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_cnt  <= '0;
         lat_exp  <= '0;
         beat_cnt <= '0;
         beat_exp <= '0;
      end else if (start && !busy) begin
         lat_cnt  <= '0;
         lat_exp  <= 32'(blk_calc) * NCB;
         beat_cnt <= '0;
         beat_exp <= 32'(blk_calc);
      end else begin
         lat_cnt  <= lat_cnt + 1;
         beat_cnt <= beat_cnt + 32'(out_valid);
      end
   end

   assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start_err |-> ($past(start) && $past(busy)));

   assert_err_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy) |=> start_err);

   assert_beat_in_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(busy));

   assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_data));

   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy || done));

   assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat_cnt == lat_exp));

   assert_beat_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((beat_cnt + 32'(out_valid)) == beat_exp));

endmodule

bind toeplitz_pa pa_checker #(.N(N), .B(B), .SF_W(SF_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .sfactor   (sfactor),
   .busy      (busy),
   .out_valid (out_valid),
   .out_data  (out_data),
   .done      (done),
   .start_err (start_err)
);

// File: tb/sim_toeplitz_pa.sv
module sim_toeplitz_pa;

   localparam int CLK_PERIOD = 10;
   localparam int N    = 64;
   localparam int B    = 4;
   localparam int SF_W = 16;
   localparam int NCB  = N / B;
   localparam int NV   = 6;

   // {sfactor, key generator seed, seed generator seed}
   localparam logic [79:0] VEC [NV] = '{
      {16'h8000, 32'h1234ABCD, 32'h0BADF00D},
      {16'hFFFF, 32'h9E3779B9, 32'h7F4A7C15},
      {16'h1C00, 32'hDEADBEEF, 32'hC0FFEE11},
      {16'h4CCD, 32'h13579BDF, 32'h2468ACE0},
      {16'h0400, 32'h55AA55AA, 32'hA5A5F00F},
      {16'h1000, 32'h87654321, 32'h0F1E2D3C}
   };

   logic                     clk = 1'b0;
   logic                     rst_n = 1'b0;
   logic                     key_we = 1'b0;
   logic [$clog2(NCB)-1:0]   key_waddr = '0;
   logic [B-1:0]             key_wdata = '0;
   logic                     seed_we = 1'b0;
   logic [$clog2(2*NCB)-1:0] seed_waddr = '0;
   logic [B-1:0]             seed_wdata = '0;
   logic                     start = 1'b0;
   logic [SF_W-1:0]          sfactor = '0;
   logic                     busy;
   logic                     out_valid;
   logic [B-1:0]             out_data;
   logic                     done;
   logic                     start_err;

   int errors = 0;
   int checks = 0;
   logic [N-1:0]   key_m;
   logic [2*N-1:0] seed_m;

   always #(CLK_PERIOD / 2) clk = ~clk;

   toeplitz_pa #(.N(N), .B(B), .SF_W(SF_W)) u0 (
      .clk(clk), .rst_n(rst_n),
      .key_we(key_we), .key_waddr(key_waddr), .key_wdata(key_wdata),
      .seed_we(seed_we), .seed_waddr(seed_waddr), .seed_wdata(seed_wdata),
      .start(start), .sfactor(sfactor),
      .busy(busy), .out_valid(out_valid), .out_data(out_data),
      .done(done), .start_err(start_err)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] xs(input logic [31:0] v);
      logic [31:0] x = v;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   // row i of the hash, straight from the definition
   function automatic logic ref_row(input int i);
      logic r = 1'b0;
      for (int j = 0; j < N; j++) begin
         if (key_m[j]) r = r ^ seed_m[i - j + N - 1];
      end
      return r;
   endfunction

   task automatic load_stores();
      for (int a = 0; a < NCB; a++) begin
         key_we = 1'b1; key_waddr = a[$clog2(NCB)-1:0]; key_wdata = key_m[a*B +: B];
         @(negedge clk);
      end
      key_we = 1'b0;
      for (int a = 0; a < 2 * NCB; a++) begin
         seed_we = 1'b1; seed_waddr = a[$clog2(2*NCB)-1:0]; seed_wdata = seed_m[a*B +: B];
         @(negedge clk);
      end
      seed_we = 1'b0;
   endtask

   task automatic gen_stores(input logic [31:0] kg, input logic [31:0] sg);
      logic [31:0] x = kg;
      for (int w = 0; w < N / 32; w++) begin x = xs(x); key_m[w*32 +: 32] = x; end
      x = sg;
      for (int w = 0; w < 2 * N / 32; w++) begin x = xs(x); seed_m[w*32 +: 32] = x; end
      load_stores();
   endtask

   task automatic run_one(input logic [SF_W-1:0] sf, input bit inj);
      int m_exp, nb_exp, cnt, beats;
      bit err_seen;
      logic [B-1:0] exp_b;
      m_exp  = (N * int'(sf)) >> SF_W;
      m_exp  = m_exp - (m_exp % B);
      nb_exp = m_exp / B;
      start = 1'b1; sfactor = sf;
      @(negedge clk);
      start = 1'b0;
      cnt = 0; beats = 0; err_seen = 0;
      chk(busy == (nb_exp > 0), "R8", "busy after accepted start", 64'(busy), 64'(nb_exp > 0));
      forever begin
         if (out_valid) begin
            for (int k = 0; k < B; k++) exp_b[k] = ref_row(beats * B + k);
            chk(out_data == exp_b, "R3 R4", $sformatf("beat %0d data", beats),
                64'(out_data), 64'(exp_b));
            beats++;
         end
         if (start_err) err_seen = 1;
         if (done) break;
         if (cnt > 4000) break;
         if (inj && cnt == 2) begin
            start = 1'b1; sfactor = 16'hFFFF;
            key_we = 1'b1; key_waddr = '0; key_wdata = ~key_m[B-1:0];
            seed_we = 1'b1; seed_waddr = 4; seed_wdata = ~seed_m[4*B +: B];
         end else begin
            start = 1'b0; key_we = 1'b0; seed_we = 1'b0;
         end
         @(negedge clk);
         cnt++;
      end
      start = 1'b0; key_we = 1'b0; seed_we = 1'b0;
      chk(done == 1'b1, "R5", "done seen", 64'(done), 64'd1);
      chk(busy == 1'b0, "R8", "busy low with done", 64'(busy), 64'd0);
      chk(beats == nb_exp, "R2", $sformatf("beat count sf=%0h", sf), 64'(beats), 64'(nb_exp));
      chk(cnt == nb_exp * NCB, "R5", "done latency", 64'(cnt), 64'(nb_exp * NCB));
      if (inj) chk(err_seen, "R6", "start_err on busy start", 64'(err_seen), 64'd1);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk({busy, out_valid, done, start_err} == 4'b0, "R1", "outputs in reset",
          64'({busy, out_valid, done, start_err}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({busy, out_valid, done, start_err} == 4'b0, "R1", "outputs after reset",
          64'({busy, out_valid, done, start_err}), 64'd0);

      for (int v = 0; v < NV; v++) begin
         gen_stores(VEC[v][63:32], VEC[v][31:0]);
         run_one(VEC[v][79:64], 1'b0);
      end

      // single key bit at column 5, single seed bit at 70: only row 12 is set (R3)
      key_m = '0; key_m[5] = 1'b1;
      seed_m = '0; seed_m[70] = 1'b1;
      load_stores();
      chk(ref_row(12) == 1'b1 && ref_row(11) == 1'b0, "R3", "model diagonal", 64'(ref_row(12)), 64'd1);
      run_one(16'h8000, 1'b0);

      // start and writes injected mid-run (R6, R7), then rerun without reload
      gen_stores(VEC[0][63:32], VEC[0][31:0]);
      run_one(16'h8000, 1'b1);
      run_one(16'hFFFF, 1'b0);

      // reset mid-run abandons the run (R1)
      start = 1'b1; sfactor = 16'hFFFF;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk({busy, out_valid, done} == 3'b0, "R1", "reset mid-run", 64'({busy, out_valid, done}), 64'd0);
      rst_n = 1'b1;
      repeat (NCB + 2) @(negedge clk);
      chk({busy, out_valid, done} == 3'b0, "R1", "quiet after reset", 64'({busy, out_valid, done}), 64'd0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule